// File: doc/BRIEF.md
# Two-Thread Shared Dual-Dispatch Queue

This block holds decoded ops waiting to issue on a two-wide in-order core and chooses, each clock, up to two of them to send down the pipeline. It has one storage array of 32 entries. With one thread running, the array is a single in-order queue of 32 entries. With two threads running, the array is split into two private queues of 16 entries each, and each thread owns one half.

Two enqueue ports write ops. Each port carries a thread ID, and that ID picks the partition in two-thread mode. The execution side reports, for each thread, whether its oldest op and its second-oldest op have their operands. The dispatcher fills two issue slots from those ready bits. Within a thread it never skips an op. Across threads it uses readiness rather than a fixed alternation, so a thread whose head op is waiting on data leaves both slots to the other thread. When both threads can issue, a round-robin favour bit decides which thread fills the slots first.

Changing between one-thread and two-thread operation takes effect only while the whole array is empty. The queue presents dispatched ops combinationally from registered state in the same cycle that the ready bits are applied. The pop takes effect at the next clock edge.

Top module: `dual_dispatch_queue`

## Requirements
- R1: After reset the block is in one-thread mode (`twoThreadActive`=0), both partitions are empty, `fullOut`=0, and `dispValid`=0.
- R2: In one-thread mode all enqueued ops go to a single 32-entry queue, whatever their thread ID. `fullOut` is 2'b11 once 32 ops are held, and further enqueues are dropped. Every dispatched op reports thread 0 (`dispTid` bit = 0).
- R3: In two-thread mode, `enqTid` bit k = 1 sends port k to thread 1, and 0 sends it to thread 0. Each thread holds at most 16 ops. `fullOut[t]` is set when thread t holds 16. A full thread drops its enqueues while the other thread still accepts them.
- R4: At most two ops dispatch per cycle. Slot 1 is valid only if slot 0 is valid. Each thread's ops leave in the order they were accepted.
- R5: `opRdy[2t]` is thread t's oldest-op ready bit and `opRdy[2t+1]` is its second-oldest-op ready bit. The second op of a thread dispatches only in a cycle in which that thread's oldest op also dispatches.
- R6: A thread whose oldest op is not ready does not block the other thread. The other thread may then use both slots.
- R7: When both threads have a ready oldest op, the favoured thread fills slots first (slot 0, then slot 1), and the other thread takes any slot left over. Thread 0 is favoured after reset. The favour flips after every such contended cycle and is otherwise kept.
- R8: `modeIn` (1 = two threads) is adopted at a clock edge only if both partitions are empty and no enqueue is accepted in that cycle. Otherwise it is ignored.
- R9: When both ports target the same partition in one cycle, port 0's op is older than port 1's. If only one entry is free, port 0's op is accepted and port 1's op is dropped.
- R10: An op accepted in a cycle can dispatch no earlier than the next cycle. Ready bits for entries that do not exist are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeIn | input | 1 | Requested mode: 1 = two threads, 0 = one thread |
| enqValid | input | 2 | Enqueue request, one bit per port |
| enqTid | input | 2 | Thread ID, one bit per port |
| enqOp | input | 2*OP_W | Op payloads; port k in bits [k*OP_W +: OP_W] |
| opRdy | input | 4 | Ready bits {t1 second, t1 oldest, t0 second, t0 oldest} |
| dispValid | output | 2 | Issue slot valid, one bit per slot |
| dispTid | output | 2 | Thread ID of each issue slot |
| dispOp | output | 2*OP_W | Issued ops; slot s in bits [s*OP_W +: OP_W] |
| fullOut | output | 2 | Partition full, one bit per thread |
| twoThreadActive | output | 1 | Mode currently in force |

## Verification
A wrong head or tail pointer shows at the issue slots in the first cycle that the affected entry is offered. The op value then differs from the one the scoreboard queued for that thread, or an op appears that was never accepted. A wrong occupancy count shows as `fullOut` set one entry early or late, or as an op that should have been dropped reaching the slots after the queue drains. A wrong favour bit or slot-fill order changes `dispTid` in the very cycle that two ready threads contend. The bench therefore compares thread IDs cycle by cycle in contended, stalled and partially ready patterns.

// File: rtl/ddq_pkg.sv
package ddq_pkg;
  localparam int DEPTH = 32;
  localparam int HALF = DEPTH / 2;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int RD_PORTS = 4;

  // strobes from control to storage
  typedef struct packed {
    logic [1:0]                       wrEn;
    logic [1:0][ADDR_W-1:0]           wrAddr;
    logic [RD_PORTS-1:0][ADDR_W-1:0]  rdAddr;
    logic [1:0][1:0]                  slotSel;  // {thread, second}
  } strobe_t;
endpackage

// File: rtl/ddq_store.sv
module ddq_store
  import ddq_pkg::*;
#(
  parameter int OP_W = 16
) (
  input  logic                      clk,
  input  strobe_t                   strb,
  input  logic [1:0][OP_W-1:0]      wrData,
  output logic [1:0][OP_W-1:0]      slotData
);
  logic [OP_W-1:0] mem [DEPTH];
  logic [RD_PORTS-1:0][OP_W-1:0] rdData;

  always_ff @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (strb.wrEn[k]) mem[strb.wrAddr[k]] <= wrData[k];
    end
  end

  for (genvar r = 0; r < RD_PORTS; r++) begin : g_rd
    assign rdData[r] = mem[strb.rdAddr[r]];
  end

  for (genvar s = 0; s < 2; s++) begin : g_slot
    assign slotData[s] = rdData[strb.slotSel[s]];
  end
endmodule

// File: rtl/ddq_ctrl.sv
module ddq_ctrl
  import ddq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        modeIn,
  input  logic [1:0]  enqValid,
  input  logic [1:0]  enqTid,
  input  logic [3:0]  opRdy,
  output strobe_t     strb,
  output logic [1:0]  dispValid,
  output logic [1:0]  dispTid,
  output logic [1:0]  fullOut,
  output logic        twoThreadActive
);
  localparam int AW = ADDR_W;
  localparam int CW = CNT_W;

  logic mode, rr;
  logic [1:0][AW-1:0] head, tail;
  logic [1:0][CW-1:0] cnt;
  logic [CW-1:0] cap;
  logic [1:0] cand0, cand1;
  logic [1:0][1:0] nReady, take, pushN;
  logic fav, oth;
  logic [1:0] room;
  logic p0, p1, acc0, acc1, same, idle;
  strobe_t strbD;

  function automatic logic [AW-1:0] wrapAdd(input logic [AW-1:0] p,
                                            input logic [1:0] inc,
                                            input logic [CW-1:0] lim);
    logic [CW-1:0] s;
    s = CW'(p) + CW'(inc);
    if (s >= lim) s = s - lim;
    return s[AW-1:0];
  endfunction

  function automatic logic [AW-1:0] phys(input logic t, input logic [AW-1:0] p);
    return t ? p + AW'(HALF) : p;
  endfunction

  assign cap = mode ? CW'(HALF) : CW'(DEPTH);

  // dispatch selection
  always_comb begin
    for (int t = 0; t < 2; t++) begin
      cand0[t] = ((t == 0) || mode) && (cnt[t] != '0) && opRdy[2*t];
      cand1[t] = cand0[t] && (cnt[t] >= CW'(2)) && opRdy[2*t+1];
      nReady[t] = cand1[t] ? 2'd2 : (cand0[t] ? 2'd1 : 2'd0);
    end
    fav = rr;
    oth = !rr;
    take = '0;
    take[fav] = nReady[fav];
    room = 2'd2 - nReady[fav];
    take[oth] = (nReady[oth] > room) ? room : nReady[oth];
  end

  // enqueue acceptance
  always_comb begin
    p0 = mode & enqTid[0];
    p1 = mode & enqTid[1];
    acc0 = enqValid[0] && (cnt[p0] < cap);
    same = acc0 && (p0 == p1);
    acc1 = enqValid[1] && ((cnt[p1] + CW'(same)) < cap);
    for (int t = 0; t < 2; t++) begin
      pushN[t] = {1'b0, acc0 && (p0 == 1'(t))} + {1'b0, acc1 && (p1 == 1'(t))};
    end
    idle = (cnt[0] == '0) && (cnt[1] == '0) && !acc0 && !acc1;
  end

  // strobes
  always_comb begin
    strbD = '0;
    dispValid = '0;
    strbD.wrEn = {acc1, acc0};
    strbD.wrAddr[0] = phys(p0, tail[p0]);
    strbD.wrAddr[1] = phys(p1, wrapAdd(tail[p1], {1'b0, same}, cap));
    for (int t = 0; t < 2; t++) begin
      strbD.rdAddr[2*t]   = phys(1'(t), head[t]);
      strbD.rdAddr[2*t+1] = phys(1'(t), wrapAdd(head[t], 2'd1, cap));
    end
    if (take[fav] != 2'd0) begin
      dispValid[0] = 1'b1; strbD.slotSel[0] = {fav, 1'b0};
    end else if (take[oth] != 2'd0) begin
      dispValid[0] = 1'b1; strbD.slotSel[0] = {oth, 1'b0};
    end
    if (take[fav] == 2'd2) begin
      dispValid[1] = 1'b1; strbD.slotSel[1] = {fav, 1'b1};
    end else if (take[fav] == 2'd1 && take[oth] != 2'd0) begin
      dispValid[1] = 1'b1; strbD.slotSel[1] = {oth, 1'b0};
    end else if (take[fav] == 2'd0 && take[oth] == 2'd2) begin
      dispValid[1] = 1'b1; strbD.slotSel[1] = {oth, 1'b1};
    end
  end

  assign strb = strbD;
  assign dispTid = {strbD.slotSel[1][1], strbD.slotSel[0][1]};
  assign twoThreadActive = mode;
  assign fullOut = mode ? {cnt[1] == CW'(HALF), cnt[0] == CW'(HALF)}
                        : {2{cnt[0] == CW'(DEPTH)}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode <= 1'b0;
      rr   <= 1'b0;
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else begin
      for (int t = 0; t < 2; t++) begin
        head[t] <= wrapAdd(head[t], take[t], cap);
        tail[t] <= wrapAdd(tail[t], pushN[t], cap);
        cnt[t]  <= cnt[t] + CW'(pushN[t]) - CW'(take[t]);
      end
      if (cand0[0] && cand0[1]) rr <= !rr;
      if (idle) begin
        mode <= modeIn;
        head <= '0;
        tail <= '0;
      end
    end
  end

  // R2 R3
  cnt_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cnt[0] <= cap) && (cnt[1] <= cap));
  // R2
  single_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !mode |-> (cnt[1] == '0) && !(dispValid[0] && dispTid[0]) && !(dispValid[1] && dispTid[1]));
  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((cnt[0] != '0) || (cnt[1] != '0)) |=> $stable(mode));
  // R10
  empty_nodisp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cnt[0] == '0) |-> !(dispValid[0] && !dispTid[0]) && !(dispValid[1] && !dispTid[1]));
  // R5
  pair_depth_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid == 2'b11 && dispTid[0] == dispTid[1]) |-> (cnt[dispTid[0]] >= CW'(2)));
  // R4
  slot_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    dispValid[1] |-> dispValid[0]);
  // R7
  rr_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cand0[0] && cand0[1]) |=> (rr != $past(rr)));
endmodule

// File: rtl/dual_dispatch_queue.sv
module dual_dispatch_queue
  import ddq_pkg::*;
#(
  parameter int OP_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeIn,
  input  logic [1:0]        enqValid,
  input  logic [1:0]        enqTid,
  input  logic [2*OP_W-1:0] enqOp,
  input  logic [3:0]        opRdy,
  output logic [1:0]        dispValid,
  output logic [1:0]        dispTid,
  output logic [2*OP_W-1:0] dispOp,
  output logic [1:0]        fullOut,
  output logic              twoThreadActive
);
  strobe_t strb;
  logic [1:0][OP_W-1:0] wrData, slotData;

  assign wrData = enqOp;
  assign dispOp = slotData;

  ddq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .modeIn(modeIn), .enqValid(enqValid),
    .enqTid(enqTid), .opRdy(opRdy), .strb(strb), .dispValid(dispValid),
    .dispTid(dispTid), .fullOut(fullOut), .twoThreadActive(twoThreadActive)
  );

  ddq_store #(.OP_W(OP_W)) i_store (
    .clk(clk), .strb(strb), .wrData(wrData), .slotData(slotData)
  );
endmodule

// File: tb/test_dual_dispatch_queue.sv
module test_dual_dispatch_queue;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeIn = 1'b0;
  logic [1:0] enqValid = '0, enqTid = '0;
  logic [31:0] enqOp = '0;
  logic [3:0] opRdy = '0;
  logic [1:0] dispValid, dispTid, fullOut;
  logic [31:0] dispOp;
  logic twoThreadActive;

  int checks = 0, errors = 0;
  bit modeB = 1'b0;
  bit done = 1'b0;
  logic [15:0] sb0[$];
  logic [15:0] sb1[$];

  always #4 clk = ~clk;

  dual_dispatch_queue i_dual_dispatch_queue (
    .clk(clk), .rstN(rstN), .modeIn(modeIn), .enqValid(enqValid), .enqTid(enqTid),
    .enqOp(enqOp), .opRdy(opRdy), .dispValid(dispValid), .dispTid(dispTid),
    .dispOp(dispOp), .fullOut(fullOut), .twoThreadActive(twoThreadActive)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model(input bit tid, input logic [15:0] op);
    int part, cap;
    part = modeB ? int'(tid) : 0;
    cap = modeB ? 16 : 32;
    if (part == 0) begin
      if (sb0.size() < cap) sb0.push_back(op);
    end else begin
      if (sb1.size() < cap) sb1.push_back(op);
    end
  endtask

  // driver: set inputs at falling edge, record expected items
  task automatic drive(input bit v0, input bit t0, input logic [15:0] o0,
                       input bit v1, input bit t1, input logic [15:0] o1,
                       input logic [3:0] rdy, input bit md);
    @(negedge clk);
    enqValid = {v1, v0};
    enqTid = {t1, t0};
    enqOp = {o1, o0};
    opRdy = rdy;
    modeIn = md;
    if (v0) model(t0, o0);
    if (v1) model(t1, o1);
    #1;
  endtask

  // monitor: pop and compare dispatched ops
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rstN) begin
        if (dispValid[1] && !dispValid[0])
          chk(1'b0, "R4 slot1 without slot0", dispValid, 2'b11);
        for (int s = 0; s < 2; s++) begin
          if (dispValid[s]) begin
            logic [15:0] got, exp;
            got = dispOp[s*16 +: 16];
            if (!modeB && dispTid[s]) chk(1'b0, "R2 thread id in one-thread mode", dispTid[s], 0);
            if (dispTid[s] == 1'b0) begin
              if (sb0.size() == 0) begin
                chk(1'b0, "R4 unexpected op thread0", got, 0);
              end else begin
                exp = sb0.pop_front();
                chk(got == exp, "R4 order thread0", got, exp);
              end
            end else begin
              if (sb1.size() == 0) begin
                chk(1'b0, "R4 unexpected op thread1", got, 0);
              end else begin
                exp = sb1.pop_front();
                chk(got == exp, "R4 order thread1", got, exp);
              end
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1
    chk(dispValid == 2'b00, "R1 dispValid", dispValid, 0);
    chk(fullOut == 2'b00, "R1 fullOut", fullOut, 0);
    chk(twoThreadActive == 1'b0, "R1 mode", twoThreadActive, 0);

    // R2: fill single queue, thread ID ignored, 33rd dropped
    for (int i = 0; i < 33; i++)
      drive(1, i[0], 16'h0100 + 16'(i), 0, 0, 0, 4'b0000, 0);
    drive(0, 0, 0, 0, 0, 0, 4'b0000, 1);
    chk(fullOut == 2'b11, "R2 full at 32", fullOut, 2'b11);
    drive(0, 0, 0, 0, 0, 0, 4'b0000, 0);
    // R8 request ignored while not empty
    chk(twoThreadActive == 1'b0, "R8 ignored when not empty", twoThreadActive, 0);
    for (int i = 0; i < 16; i++) begin
      drive(0, 0, 0, 0, 0, 0, 4'b1111, 0);
      chk(dispValid == 2'b11 && dispTid == 2'b00, "R2 drain two per cycle",
          {dispValid, dispTid}, 4'b1100);
    end
    drive(0, 0, 0, 0, 0, 0, 4'b1111, 0);
    chk(dispValid == 2'b00, "R2 dropped op never issued", dispValid, 0);
    chk(sb0.size() == 0, "R2 scoreboard empty", sb0.size(), 0);

    // R10: no same-cycle bypass, absent second entry ignored
    drive(1, 0, 16'h0200, 0, 0, 0, 4'b1111, 0);
    chk(dispValid == 2'b00, "R10 no bypass", dispValid, 0);
    drive(0, 0, 0, 0, 0, 0, 4'b1111, 0);
    chk(dispValid == 2'b01, "R10 single entry", dispValid, 2'b01);

    // R9 port order, R5 in-order pairing
    drive(1, 0, 16'h0300, 1, 0, 16'h0301, 4'b0000, 0);
    drive(0, 0, 0, 0, 0, 0, 4'b0010, 0);
    chk(dispValid == 2'b00, "R5 second ready alone", dispValid, 0);
    drive(0, 0, 0, 0, 0, 0, 4'b0011, 0);
    chk(dispValid == 2'b11 && dispTid == 2'b00, "R5 pair issue", {dispValid, dispTid}, 4'b1100);

    // R8 switch while empty
    drive(0, 0, 0, 0, 0, 0, 4'b0000, 1);
    modeB = 1'b1;
    drive(0, 0, 0, 0, 0, 0, 4'b0000, 1);
    chk(twoThreadActive == 1'b1, "R8 switch when empty", twoThreadActive, 1);

    // R3 thread1 partition fill, R9 last slot
    for (int i = 0; i < 15; i++)
      drive(0, 0, 0, 1, 1, 16'h1100 + 16'(i), 4'b0000, 1);
    drive(1, 1, 16'h11F0, 1, 1, 16'h11F1, 4'b0000, 1);
    drive(0, 0, 0, 0, 0, 0, 4'b0000, 1);
    chk(fullOut == 2'b10, "R3 R9 thread1 full", fullOut, 2'b10);
    drive(1, 0, 16'h0400, 1, 1, 16'h11F2, 4'b0000, 1);
    for (int i = 1; i < 5; i++)
      drive(1, 0, 16'h0400 + 16'(i), 0, 0, 0, 4'b0000, 1);
    drive(0, 0, 0, 0, 0, 0, 4'b0000, 1);
    chk(fullOut == 2'b10, "R3 thread0 still accepting", fullOut, 2'b10);

    // R6 stalled thread0
    drive(0, 0, 0, 0, 0, 0, 4'b1100, 1);
    chk(dispValid == 2'b11 && dispTid == 2'b11, "R6 other thread issues", {dispValid, dispTid}, 4'b1111);
    // R7 contention sequence
    drive(0, 0, 0, 0, 0, 0, 4'b1111, 1);
    chk(dispValid == 2'b11 && dispTid == 2'b00, "R7 thread0 favoured", {dispValid, dispTid}, 4'b1100);
    drive(0, 0, 0, 0, 0, 0, 4'b1111, 1);
    chk(dispValid == 2'b11 && dispTid == 2'b11, "R7 favour flips", {dispValid, dispTid}, 4'b1111);
    drive(0, 0, 0, 0, 0, 0, 4'b1101, 1);
    chk(dispValid == 2'b11 && dispTid == 2'b10, "R7 leftover slot", {dispValid, dispTid}, 4'b1110);
    drive(0, 0, 0, 0, 0, 0, 4'b1111, 1);
    chk(dispValid == 2'b11 && dispTid == 2'b11, "R7 favour thread1", {dispValid, dispTid}, 4'b1111);
    drive(0, 0, 0, 0, 0, 0, 4'b1111, 1);
    chk(dispValid == 2'b11 && dispTid == 2'b00, "R7 favour thread0", {dispValid, dispTid}, 4'b1100);

    // R8 ignored while thread1 not empty
    drive(0, 0, 0, 0, 0, 0, 4'b0000, 0);
    drive(0, 0, 0, 0, 0, 0, 4'b0000, 0);
    chk(twoThreadActive == 1'b1, "R8 hold two-thread", twoThreadActive, 1);

    for (int i = 0; i < 20; i++) begin
      if (sb0.size() == 0 && sb1.size() == 0) break;
      drive(0, 0, 0, 0, 0, 0, 4'b1111, 1);
    end
    drive(0, 0, 0, 0, 0, 0, 4'b1111, 1);
    chk(dispValid == 2'b00, "R4 drained", dispValid, 0);
    chk(sb0.size() == 0 && sb1.size() == 0, "R3 all ops issued", sb0.size() + sb1.size(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule